// File: doc/BRIEF.md
# Triple-Lane Staged Majority Voter

This block carries one data word through three copies of the same seven-stage pipeline. Each stage of each copy applies a fixed, stage-specific transform and registers the result. Behind every stage register a bitwise two-of-three vote combines the three copies. The voted word, not each copy's own result, becomes the input of the next stage in all three copies. A wrong value in one copy is therefore absorbed at the stage where it appears. Because of this, the result stays correct even when a different copy goes wrong at each stage.

The three lane inputs enter through one valid/ready port, and the voted result leaves through another. Back-pressure rules: the whole pipeline advances only when the output register is empty or the consumer asserts `out_ready`. `in_ready` equals that advance condition, so an input word is taken exactly when `in_valid && in_ready` at a clock edge. While `out_valid` is high and `out_ready` is low, `out_data` and `out_flags` hold their values and no input is accepted. Every result carries a disagreement vector that records which lane differed from the vote at which stage. A fault-injection port can overwrite one lane's result at one stage, so that masking can be tested.

Top module: `tmr_vote_pipe`

## Requirements
- R1: After reset, `out_valid` is 0, `out_flags` is 0 and `in_ready` is 1.
- R2: Define T_k(x) as x rotated left by one bit, plus 2k+1, modulo 2^W, for stage k = 0..6. With equal lane inputs x and no injection, the result is T_6(...T_0(x)). With `out_ready` held high, the result appears 7 cycles after acceptance: `out_valid` is low on the six cycles after the accepting edge and high on the seventh.
- R3: Stage 0 applies T_0 to each lane's own input. The stage-0 vote is the bitwise majority (a&b)|(a&c)|(b&c) of the three results, and later stages transform that voted word.
- R4: While `inj_en` is 1, the stage numbered `inj_stage` loads `inj_value` into lane `inj_lane` in place of its computed result (lane 0 = a, 1 = b, 2 = c). A fault in one lane at one stage does not change `out_data`.
- R5: An item with a fault injected in one lane at every one of the seven stages, with the lane changing from stage to stage, still produces the fault-free `out_data`.
- R6: `out_flags` bit 3*k+l is 1 when lane l's stage-k result differed from the stage-k vote for that item. The flags travel with the item, and `out_flags` is 0 whenever `out_valid` is 0.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_data`, `out_flags` and `out_valid` stay unchanged on the next cycle; no item is lost or duplicated.
- R8: Cycles with `in_valid` low produce no result, and results come out in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Lane inputs hold a word |
| in_ready | output | 1 | Pipeline advances this cycle |
| in_lane_a | input | W | Lane 0 input word |
| in_lane_b | input | W | Lane 1 input word |
| in_lane_c | input | W | Lane 2 input word |
| inj_en | input | 1 | Enable fault injection |
| inj_lane | input | 2 | Lane to corrupt (0..2) |
| inj_stage | input | SEL_W | Stage to corrupt (0..6) |
| inj_value | input | W | Value forced into the chosen lane register |
| out_valid | output | 1 | Voted result available |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | W | Voted result of the last stage |
| out_flags | output | 3*STAGES | Per-stage, per-lane disagreement flags |

## Verification
The main function is driven with three kinds of lane input. Equal lanes check the transform chain and the latency. Inputs where one lane differs check that stage 0 masks the odd lane and flags it. Inputs where all three lanes differ show that the vote is bitwise and not a whole-word vote.

Injected faults are placed at each single stage in turn, and then at all seven stages on one item with a rotating lane. These runs tell apart a design that votes once at the end from one that feeds the vote forward at each stage. Random output stalls and input bubbles check that the flags stay attached to their own item.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_LANES = 3;
  localparam int LANE_IDX_W = 2;
  typedef enum logic [LANE_IDX_W-1:0] {
    LANE_A = 2'd0,
    LANE_B = 2'd1,
    LANE_C = 2'd2
  } lane_e;
endpackage

// File: rtl/tmr_lane_stage.sv
module tmr_lane_stage #(
  parameter int W = 16,
  parameter int STAGE_IDX = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] din,
  input  logic         inj_hit,
  input  logic [W-1:0] inj_value,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] ADD_K = W'(2 * STAGE_IDX + 1);

  logic [W-1:0] xf;
  assign xf = {din[W-2:0], din[W-1]} + ADD_K;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (adv) q <= inj_hit ? inj_value : xf;
  end

  assert_hold_when_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(q));

  assert_inject_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && inj_hit) |=> (q == $past(inj_value)));
endmodule

// File: rtl/tmr_voter.sv
module tmr_voter #(
  parameter int W = 16
) (
  input  logic         valid,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] voted,
  output logic [2:0]   mism
);
  assign voted = (a & b) | (a & c) | (b & c);

  always_comb begin
    mism[0] = valid && (a != voted);
    mism[1] = valid && (b != voted);
    mism[2] = valid && (c != voted);
  end

  always_comb begin
    assert_pair_agree_R6: assert (!(valid && (a == b)) || (!mism[0] && !mism[1]));
    assert_unanimous_R3: assert (!((a == b) && (b == c)) || ((voted == a) && (mism == 3'b000)));
  end
endmodule

// File: rtl/tmr_vote_pipe.sv
module tmr_vote_pipe #(
  parameter int W = 16,
  parameter int STAGES = 7,
  localparam int SEL_W = (STAGES > 1) ? $clog2(STAGES) : 1,
  localparam int FLAG_W = tmr_pkg::NUM_LANES * STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [W-1:0]      in_lane_a,
  input  logic [W-1:0]      in_lane_b,
  input  logic [W-1:0]      in_lane_c,
  input  logic              inj_en,
  input  logic [1:0]        inj_lane,
  input  logic [SEL_W-1:0]  inj_stage,
  input  logic [W-1:0]      inj_value,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [W-1:0]      out_data,
  output logic [FLAG_W-1:0] out_flags
);
  import tmr_pkg::*;

  logic              adv;
  logic [W-1:0]      lane_q [STAGES][NUM_LANES];
  logic [W-1:0]      voted  [STAGES];
  logic [2:0]        mism   [STAGES];
  logic [FLAG_W-1:0] mark   [STAGES];
  logic              valid_q[STAGES];
  logic [FLAG_W-1:0] flag_q [STAGES];
  logic [W-1:0]      lane_in[NUM_LANES];

  assign lane_in[LANE_A] = in_lane_a;
  assign lane_in[LANE_B] = in_lane_b;
  assign lane_in[LANE_C] = in_lane_c;

  assign adv      = !valid_q[STAGES-1] || out_ready;
  assign in_ready = adv;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      logic hit;
      assign hit = inj_en && (inj_stage == SEL_W'(s)) && (inj_lane == 2'(l));
      tmr_lane_stage #(.W(W), .STAGE_IDX(s)) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .din      ((s == 0) ? lane_in[l] : voted[(s == 0) ? 0 : s-1]),
        .inj_hit  (hit),
        .inj_value(inj_value),
        .q        (lane_q[s][l])
      );
    end

    tmr_voter #(.W(W)) u_vote (
      .valid(valid_q[s]),
      .a    (lane_q[s][0]),
      .b    (lane_q[s][1]),
      .c    (lane_q[s][2]),
      .voted(voted[s]),
      .mism (mism[s])
    );

    assign mark[s] = FLAG_W'(mism[s]) << (NUM_LANES * s);

    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          valid_q[0] <= 1'b0;
          flag_q[0]  <= '0;
        end else if (adv) begin
          valid_q[0] <= in_valid;
          flag_q[0]  <= '0;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          valid_q[s] <= 1'b0;
          flag_q[s]  <= '0;
        end else if (adv) begin
          valid_q[s] <= valid_q[s-1];
          flag_q[s]  <= flag_q[s-1] | mark[s-1];
        end
      end
    end
  end

  assign out_valid = valid_q[STAGES-1];
  assign out_data  = voted[STAGES-1];
  assign out_flags = out_valid ? (flag_q[STAGES-1] | mark[STAGES-1]) : '0;

  assert_output_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_flags)));

  assert_stall_blocks_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/tmr_vote_pipe_tb.sv
module tmr_vote_pipe_tb;
  localparam int W = 16;
  localparam int S = 7;
  localparam int FW = 3 * S;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [W-1:0] in_a = 0, in_b = 0, in_c = 0;
  logic inj_en = 0;
  logic [1:0] inj_lane = 0;
  logic [2:0] inj_stage = 0;
  logic [W-1:0] inj_value = 0;
  logic out_valid, out_ready = 1;
  logic [W-1:0] out_data;
  logic [FW-1:0] out_flags;

  always #2.5 clk = ~clk;

  tmr_vote_pipe #(.W(W), .STAGES(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_lane_a(in_a), .in_lane_b(in_b), .in_lane_c(in_c),
    .inj_en(inj_en), .inj_lane(inj_lane), .inj_stage(inj_stage), .inj_value(inj_value),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_flags(out_flags)
  );

  typedef struct packed { logic [W-1:0] d; logic [FW-1:0] f; } exp_t;
  exp_t sb[$];
  int checks = 0, failures = 0;
  string cur_req = "R1";
  int plan_lane[S];
  logic [W-1:0] plan_val[S];
  bit stall_on = 0;
  bit done = 0;

  function automatic logic [W-1:0] xf(logic [W-1:0] x, int k);
    return {x[W-2:0], x[W-1]} + W'(2 * k + 1);
  endfunction

  function automatic logic [W-1:0] maj(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic exp_t model(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    exp_t e;
    logic [W-1:0] t[3];
    logic [W-1:0] cur[3];
    logic [W-1:0] v;
    cur[0] = a; cur[1] = b; cur[2] = c;
    e.f = '0;
    v = '0;
    for (int k = 0; k < S; k++) begin
      for (int l = 0; l < 3; l++) t[l] = xf(cur[l], k);
      if (plan_lane[k] >= 0) t[plan_lane[k]] = plan_val[k];
      v = maj(t[0], t[1], t[2]);
      for (int l = 0; l < 3; l++) if (t[l] != v) e.f[3 * k + l] = 1'b1;
      for (int l = 0; l < 3; l++) cur[l] = v;
    end
    e.d = v;
    return e;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_plan();
    for (int k = 0; k < S; k++) begin plan_lane[k] = -1; plan_val[k] = '0; end
  endtask

  task automatic set_inj(int k);
    inj_en = (plan_lane[k] >= 0);
    inj_stage = 3'(k);
    inj_lane = 2'(plan_lane[k] < 0 ? 0 : plan_lane[k]);
    inj_value = plan_val[k];
  endtask

  task automatic send(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    bit faulty = 0;
    for (int k = 0; k < S; k++) if (plan_lane[k] >= 0) faulty = 1;
    @(negedge clk);
    in_valid = 1; in_a = a; in_b = b; in_c = c;
    set_inj(0);
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    sb.push_back(model(a, b, c));
    if (faulty) begin
      for (int k = 1; k < S; k++) begin
        @(negedge clk);
        in_valid = 0;
        set_inj(k);
      end
      @(negedge clk);
      inj_en = 0;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); in_valid = 0; end
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && sb.size() != 0; i++) @(negedge clk);
    check(sb.size() == 0, cur_req, "items still pending", sb.size(), 0);
  endtask

  always @(negedge clk) begin
    if (stall_on) out_ready = ($urandom % 3) != 0;
    else out_ready = 1;
  end

  bit held_prev = 0;
  logic [W-1:0] held_d;
  logic [FW-1:0] held_f;
  always @(negedge clk) begin
    #1.5;
    if (rst_n && !done) begin
      if (held_prev) begin
        check(out_valid && out_data == held_d && out_flags == held_f, "R7",
              "output changed while stalled", out_data, held_d);
      end
      if (out_valid && !out_ready)
        check(!in_ready, "R7", "in_ready during stall", in_ready, 0);
      if (!out_valid && out_flags != 0)
        check(0, "R6", "flags without valid", out_flags, 0);
      if (out_valid && out_ready) begin
        if (sb.size() == 0) check(0, "R8", "unexpected result", out_data, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          check(out_data == e.d, cur_req, "data", out_data, e.d);
          check(out_flags == e.f, "R6", "flags", out_flags, e.f);
        end
      end
      held_prev = out_valid && !out_ready;
      held_d = out_data;
      held_f = out_flags;
    end
  end

  initial begin
    #(200000 * 5);
    check(0, "WDOG", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clear_plan();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    cur_req = "R1";
    check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    check(out_flags == 0, "R1", "out_flags after reset", out_flags, 0);
    check(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);

    // R2: latency of one item
    cur_req = "R2";
    send(16'h1234, 16'h1234, 16'h1234);
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      in_valid = 0;
      #1;
      check(out_valid == (k == 7), "R2", "latency out_valid", out_valid, (k == 7));
    end
    drain();
    // R2: back-to-back equal-lane stream
    for (int i = 0; i < 20; i++) begin
      logic [W-1:0] x;
      x = W'($urandom);
      send(x, x, x);
    end
    idle(1);
    drain();

    // R3: one lane differs, then all three differ (bitwise vote)
    cur_req = "R3";
    send(16'hAAAA, 16'h5555, 16'hAAAA);
    send(16'h00FF, 16'h0F0F, 16'h3333);
    for (int i = 0; i < 10; i++) send(W'($urandom), W'($urandom), W'($urandom));
    idle(1);
    drain();

    // R4: single fault at each stage
    cur_req = "R4";
    for (int k = 0; k < S; k++) begin
      clear_plan();
      plan_lane[k] = k % 3;
      plan_val[k] = W'($urandom) | 16'h0001;
      send(16'hBEEF, 16'hBEEF, 16'hBEEF);
      check(model(16'hBEEF, 16'hBEEF, 16'hBEEF).d == sb[sb.size()-1].d, "R4",
            "model masks fault", 0, 0);
      drain();
    end

    // R5: faults at all stages, rotating lane
    cur_req = "R5";
    for (int r = 0; r < 3; r++) begin
      exp_t clean;
      clear_plan();
      clean = model(16'hC0DE + 16'(r), 16'hC0DE + 16'(r), 16'hC0DE + 16'(r));
      for (int k = 0; k < S; k++) begin
        plan_lane[k] = (k + r) % 3;
        plan_val[k] = ~W'(k * 16'h1111);
      end
      send(16'hC0DE + 16'(r), 16'hC0DE + 16'(r), 16'hC0DE + 16'(r));
      check(sb[sb.size()-1].d == clean.d, "R5", "faulted item equals clean result",
            sb[sb.size()-1].d, clean.d);
      drain();
    end
    clear_plan();

    // R6: flags on a stage-0 disagreement of lane b
    cur_req = "R6";
    send(16'h0101, 16'h0102, 16'h0101);
    check(sb[sb.size()-1].f == 21'b010, "R6", "expected flag slot", sb[sb.size()-1].f, 21'b010);
    idle(1);
    drain();

    // R7: random output stalls
    cur_req = "R7";
    stall_on = 1;
    for (int i = 0; i < 30; i++) begin
      logic [W-1:0] x;
      x = W'($urandom);
      if (i % 4 == 0) send(x, x ^ 16'h0010, x);
      else send(x, x, x);
    end
    idle(1);
    drain();
    stall_on = 0;

    // R8: bubbles between items
    cur_req = "R8";
    for (int i = 0; i < 10; i++) begin
      logic [W-1:0] x;
      x = W'($urandom);
      send(x, x, x);
      idle(i % 3 + 1);
    end
    drain();
    idle(10);
    check(out_valid == 0, "R8", "no result after idle", out_valid, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule